// File: doc/BRIEF.md
# Crosspoint Switch Control Memory

This block keeps the on/off pattern of a square crosspoint fabric made of row lines and column lines. Each intersection has one storage cell, and each cell's output drives the enable of one switch. There is no read path. A cell is written by giving a row field, a column field and a data bit, pulling the active-low select and the active-low strobe low, and then raising the strobe.

Each cell is a level-sensitive latch with an asynchronous clear. It is not an edge-triggered flop. While select and strobe are both low, the addressed cell passes the data input straight through to its output. When the strobe goes high, the cell keeps whatever value was on the data input at that moment. An active-low master reset clears every cell at once. The select input has no influence on the reset. When several devices share the address, data and strobe lines, the select input picks which one takes a write.

Top module: `xpt_ctrl_store`

## Requirements
- R1: While `rst_n` is low, every bit of `sw_en_o` is 0. This holds whatever `cs_n` is.
- R2: The row field `addr_x` and the column field `addr_y` are binary indices. A write reaches output bit `addr_y*8 + addr_x`. For example, row 5 with column 0 is bit 5, and row 7 with column 7 is bit 63. A data value of 1 turns the switch on and 0 turns it off.
- R3: A write alters only the addressed bit. The other 63 bits keep their values.
- R4: While `rst_n` is high and `cs_n` and `strobe_n` are both low, the addressed bit follows `data_i` in the same cycle, including any changes to `data_i` during that window.
- R5: After `strobe_n` rises, the addressed bit holds the value `data_i` had at the rising edge. Later changes to `data_i` have no effect on it.
- R6: While `cs_n` is high, pulses on `strobe_n` and changes on `data_i` leave every bit unchanged.
- R7: If a write window is open when `rst_n` goes low, the addressed bit reads 0. If `strobe_n` rises while `rst_n` is still low, the bit stays 0 after `rst_n` is released.
- R8: The clear acts when `cs_n` is high just as it does when `cs_n` is low. Once `rst_n` is high again, writes work as normal.
- R9: While select and strobe are both low, exactly one cell enable is active. While select is high, none is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Master clear, active low, asynchronous |
| cs_n | input | 1 | Device select, active low |
| strobe_n | input | 1 | Write strobe, active low; the value is captured on the rising edge |
| data_i | input | 1 | Value to write (1 = switch on) |
| addr_x | input | 3 | Row index |
| addr_y | input | 3 | Column index |
| sw_en_o | output | 64 | Switch enables, bit `y*8+x` |

## Verification
The store is built from latches, so every result appears combinationally. There is no registered stage. A write, a data change inside an open window and a clear are all due at the output in the same cycle as the stimulus, zero cycles later. The bench changes its inputs just after a rising clock edge and reads `sw_en_o` at the following falling edge, half a period later, when the output has settled. For retention after a strobe edge, the bench first raises the strobe and then changes data one cycle later. It checks the output only after both steps, so the check cannot depend on which change the simulator processed first.

// File: rtl/xpt_pkg.sv
`timescale 1ns/1ps
package xpt_pkg;
  // default fabric geometry
  localparam int XPT_ROWS = 8;
  localparam int XPT_COLS = 8;

  // flat index of a cell: column-major groups of rows
  function automatic int xpt_index(input int row, input int col, input int nrows);
    return col * nrows + row;
  endfunction
endpackage

// File: rtl/xpt_cell.sv
`timescale 1ns/1ps
module xpt_cell (
  input  logic rst_n,
  input  logic we,
  input  logic d,
  output logic q
);
  // resettable transparent latch; clear dominates the write enable
  always_latch begin
    if (!rst_n)  q <= 1'b0;
    else if (we) q <= d;
  end
endmodule

// File: rtl/xpt_addr_decode.sv
`timescale 1ns/1ps
module xpt_addr_decode #(
  parameter int NX = 8,
  parameter int NY = 8,
  localparam int XW = (NX > 1) ? $clog2(NX) : 1,
  localparam int YW = (NY > 1) ? $clog2(NY) : 1,
  localparam int NC = NX * NY
) (
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          strobe_n,
  input  logic [XW-1:0] addr_x,
  input  logic [YW-1:0] addr_y,
  output logic [NC-1:0] cell_we
);
  logic [NX-1:0] x_hot;
  logic [NY-1:0] y_hot;
  logic          gate;

  assign gate = ~cs_n & ~strobe_n;

  for (genvar gx = 0; gx < NX; gx++) begin : g_xdec
    assign x_hot[gx] = (addr_x == XW'(gx));
  end
  for (genvar gy = 0; gy < NY; gy++) begin : g_ydec
    assign y_hot[gy] = (addr_y == YW'(gy));
  end

  for (genvar gy = 0; gy < NY; gy++) begin : g_col
    for (genvar gx = 0; gx < NX; gx++) begin : g_row
      assign cell_we[xpt_pkg::xpt_index(gx, gy, NX)] = gate & y_hot[gy] & x_hot[gx];
    end
  end

  // R9: a selected write window opens exactly one cell
  p_one_cell_r9: assert property (@(posedge strobe_n) disable iff (!rst_n)
    !cs_n |-> ($countones(cell_we) == 1));

  // R6: with the device deselected no cell is opened
  p_cs_block_r6: assert property (@(posedge strobe_n) disable iff (!rst_n)
    cs_n |-> (cell_we == '0));
endmodule

// File: rtl/xpt_latch_array.sv
`timescale 1ns/1ps
module xpt_latch_array #(
  parameter int NC = 64
) (
  input  logic          rst_n,
  input  logic [NC-1:0] cell_we,
  input  logic          data_i,
  output logic [NC-1:0] q
);
  for (genvar gc = 0; gc < NC; gc++) begin : g_cell
    xpt_cell u_cell (
      .rst_n (rst_n),
      .we    (cell_we[gc]),
      .d     (data_i),
      .q     (q[gc])
    );
  end

  // R1: the store comes out of a clear fully off
  p_reset_clear_r1: assert property (@(posedge rst_n) disable iff (!rst_n)
    1'b1 |-> (q == '0));
endmodule

// File: rtl/xpt_ctrl_store.sv
`timescale 1ns/1ps
module xpt_ctrl_store #(
  parameter int NX = xpt_pkg::XPT_ROWS,
  parameter int NY = xpt_pkg::XPT_COLS,
  localparam int XW = (NX > 1) ? $clog2(NX) : 1,
  localparam int YW = (NY > 1) ? $clog2(NY) : 1,
  localparam int NC = NX * NY
) (
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          strobe_n,
  input  logic          data_i,
  input  logic [XW-1:0] addr_x,
  input  logic [YW-1:0] addr_y,
  output logic [NC-1:0] sw_en_o
);
  logic [NC-1:0] cell_we;

  xpt_addr_decode #(.NX(NX), .NY(NY)) u_dec (
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .strobe_n (strobe_n),
    .addr_x   (addr_x),
    .addr_y   (addr_y),
    .cell_we  (cell_we)
  );

  xpt_latch_array #(.NC(NC)) u_store (
    .rst_n   (rst_n),
    .cell_we (cell_we),
    .data_i  (data_i),
    .q       (sw_en_o)
  );

  // R5/R2: just before strobe closes, the addressed switch mirrors data
  p_capture_r5: assert property (@(posedge strobe_n) disable iff (!rst_n)
    !cs_n |-> (sw_en_o[int'(addr_y) * NX + int'(addr_x)] == data_i));
endmodule

// File: tb/xpt_ctrl_store_test.sv
`timescale 1ns/1ps
module xpt_ctrl_store_test;
  logic        clk = 1'b0;
  logic        rst_n, cs_n, strobe_n, data_i;
  logic [2:0]  addr_x, addr_y;
  logic [63:0] sw_en_o;
  logic [63:0] exp_v;
  int          n_cmp = 0;
  int          n_bad = 0;

  always #5 clk = ~clk;

  xpt_ctrl_store uut (
    .rst_n(rst_n), .cs_n(cs_n), .strobe_n(strobe_n), .data_i(data_i),
    .addr_x(addr_x), .addr_y(addr_y), .sw_en_o(sw_en_o)
  );

  // write vectors: {data, column[2:0], row[2:0]}
  localparam logic [6:0] WR_TAB [12] = '{
    {1'b1, 3'd0, 3'd5}, {1'b1, 3'd7, 3'd7}, {1'b1, 3'd0, 3'd0},
    {1'b1, 3'd3, 3'd2}, {1'b1, 3'd2, 3'd3}, {1'b0, 3'd0, 3'd5},
    {1'b1, 3'd4, 3'd6}, {1'b1, 3'd6, 3'd1}, {1'b0, 3'd7, 3'd7},
    {1'b1, 3'd1, 3'd7}, {1'b0, 3'd3, 3'd2}, {1'b1, 3'd5, 3'd4}
  };

  task automatic check(input string tag, input logic [63:0] want);
    @(negedge clk);
    n_cmp++;
    if (sw_en_o !== want) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, sw_en_o, want);
    end
  endtask

  task automatic do_write(input logic [2:0] x, input logic [2:0] y, input logic d);
    @(posedge clk); addr_x = x; addr_y = y; data_i = d; cs_n = 1'b0;
    @(posedge clk); strobe_n = 1'b0;
    @(posedge clk); strobe_n = 1'b1;
    @(posedge clk); cs_n = 1'b1;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; strobe_n = 1'b1; data_i = 1'b0;
    addr_x = '0; addr_y = '0;
    exp_v = '0;
    repeat (3) @(posedge clk);
    check("R1 reset state", 64'h0);
    @(posedge clk); rst_n = 1'b1;
    check("R1 after release", 64'h0);

    // table walk: R2 index mapping, R3 isolation, R9 single cell
    for (int i = 0; i < 12; i++) begin
      logic [6:0] e;
      e = WR_TAB[i];
      do_write(e[2:0], e[5:3], e[6]);
      exp_v[int'(e[5:3]) * 8 + int'(e[2:0])] = e[6];
      check($sformatf("R2/R3/R9 table write %0d", i), exp_v);
    end
    // literal check of mapping: bits 0,15,19,38,44,49 set
    check("R2 literal mapping", 64'h0002_1040_0008_8001);

    // R4 transparency
    @(posedge clk); addr_x = 3'd2; addr_y = 3'd6; data_i = 1'b1; cs_n = 1'b0;
    @(posedge clk); strobe_n = 1'b0;
    exp_v[50] = 1'b1;
    check("R4 open window follows 1", exp_v);
    @(posedge clk); data_i = 1'b0;
    exp_v[50] = 1'b0;
    check("R4 open window follows 0", exp_v);
    @(posedge clk); data_i = 1'b1;
    exp_v[50] = 1'b1;
    check("R4 open window follows 1 again", exp_v);
    // R5 retention after strobe rise
    @(posedge clk); strobe_n = 1'b1;
    @(posedge clk); data_i = 1'b0;
    check("R5 retained after data change", exp_v);
    @(posedge clk); cs_n = 1'b1;

    // R6 deselected activity ignored
    @(posedge clk); addr_x = 3'd0; addr_y = 3'd0; data_i = 1'b0;
    @(posedge clk); strobe_n = 1'b0;
    @(posedge clk); data_i = 1'b1;
    check("R6 strobe low while deselected", exp_v);
    @(posedge clk); strobe_n = 1'b1;
    @(posedge clk); addr_x = 3'd3; addr_y = 3'd3; data_i = 1'b1;
    @(posedge clk); strobe_n = 1'b0;
    @(posedge clk); strobe_n = 1'b1;
    check("R6 second deselected pulse", exp_v);

    // R8 reset with cs high clears all
    @(posedge clk); cs_n = 1'b1; rst_n = 1'b0;
    exp_v = '0;
    check("R8 clear while deselected", exp_v);
    @(posedge clk); rst_n = 1'b1;
    do_write(3'd7, 3'd7, 1'b1);
    exp_v[63] = 1'b1;
    check("R8 write after clear", exp_v);

    // R7 reset overrides an open write window
    @(posedge clk); addr_x = 3'd1; addr_y = 3'd2; data_i = 1'b1; cs_n = 1'b0;
    @(posedge clk); strobe_n = 1'b0;
    exp_v[17] = 1'b1;
    check("R7 window open before clear", exp_v);
    @(posedge clk); rst_n = 1'b0;
    exp_v = '0;
    check("R7 clear during open window", exp_v);
    @(posedge clk); strobe_n = 1'b1;
    @(posedge clk); rst_n = 1'b1;
    check("R7 bit stays off after release", exp_v);
    @(posedge clk); cs_n = 1'b1;

    // R1/R8 clear with cs low
    do_write(3'd0, 3'd0, 1'b1);
    exp_v[0] = 1'b1;
    check("R2 corner cell 0", exp_v);
    @(posedge clk); cs_n = 1'b0; rst_n = 1'b0;
    check("R1 clear while selected", 64'h0);
    @(posedge clk); rst_n = 1'b1; cs_n = 1'b1;
    check("R1 idle after clear", 64'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule